// File: doc/BRIEF.md
# Infrared Run-Length Receiver

This block watches one infrared receiver line and stores the waveform as a sequence of run-length bytes in a receive FIFO. The line passes through a two-stage synchronizer, with optional inversion ahead of it. It is sampled once every 64 or 128 module clocks. A glitch filter then ignores level changes that do not persist for a programmable number of samples.

A frame begins only after the filtered line has been at mark level for a qualifying number of samples. From then on, every run of constant level becomes one byte: a level bit and a 7-bit length in samples. Runs longer than 127 samples are split into several entries. A long stretch of space closes the frame, writes the final entry and raises a packet-end flag. Software reads entries through a read strobe and watches three sticky flags: overflow, packet end and data available. The fill count sits in the same status word. Each flag has its own interrupt enable, and writing ones clears flags.

Top module: `cir_rl_rx`

## Requirements
- R1: The line is sampled once every 64 module clocks when `slow_sel` is 0 and once every 128 when it is 1. Run lengths count these samples.
- R2: Each entry holds the run level in bit 7 (1 = mark, 0 = space) and the run length in samples, from 1 to 127, in bits 6:0. A run of 127 samples writes an entry of length 127, and the same level continues in a new entry.
- R3: With filter value F, a level change on the line is accepted only after it has lasted F samples. Shorter excursions leave no trace in the stored runs.
- R4: With active value T and scale bit S, a frame begins after T+1 mark samples (S=0) or (T+1)*128 mark samples (S=1). A shorter mark stores nothing. The qualifying samples are not counted in the first entry.
- R5: With idle value N, (N+1)*128 consecutive space samples end the frame. The last space entry is written and the packet-end flag is set. The block then waits for the next qualifying mark.
- R6: When `invert` is 1, a low input is treated as mark.
- R7: A new entry arriving at a full FIFO is dropped and sets the overflow flag. The fill count stays at the FIFO depth, and the flag stays set until it is cleared.
- R8: The data-available flag is set while the fill count exceeds `trig_lvl` (fill >= `trig_lvl`+1). It stays set until it is cleared.
- R9: A cycle with `clr_we` high clears each flag whose bit in `clr_mask` is 1, using the status bit positions. Other flags are unchanged.
- R10: `irq` is high when any flag whose enable bit is set is high. `irq_en` bit 0 enables overflow, bit 1 packet end and bit 2 data available.
- R11: Reception runs only when `glb_en` and `rx_en` are both 1 and `mode` equals 2'b11. Otherwise no entries are written.
- R12: `rd_data` shows the oldest entry, and `rd_stb` removes it. On an empty FIFO, `rd_data` reads 0 and `rd_stb` has no effect.
- R13: `status` carries overflow in bit 0, packet end in bit 1, data available in bit 4 and the fill count from bit 8 upward. All other bits read 0, and every field is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | module clock |
| rst_n | input | 1 | asynchronous reset, active low |
| glb_en | input | 1 | global enable |
| rx_en | input | 1 | receive enable |
| mode | input | 2 | operating mode, 2'b11 selects infrared reception |
| slow_sel | input | 1 | sample divider select, 1 = /128, 0 = /64 |
| invert | input | 1 | invert the input line |
| filt_thr | input | 6 | glitch filter length in samples |
| idle_thr | input | 8 | idle value N, frame ends after (N+1)*128 space samples |
| act_thr | input | 8 | active value T |
| act_scale | input | 1 | multiply the active threshold by 128 |
| trig_lvl | input | 4 | data-available level |
| irq_en | input | 3 | interrupt enables: avail, packet end, overflow |
| clr_we | input | 1 | flag clear strobe |
| clr_mask | input | 8 | flags to clear, status bit positions |
| ir_in | input | 1 | infrared receiver line |
| rd_stb | input | 1 | remove oldest entry |
| rd_data | output | 8 | oldest entry |
| status | output | 13 | flags and fill count |
| irq | output | 1 | interrupt request |

## Verification
A wrong internal state shows up in one of two places. A fault in the divider, filter or run counters shows as a wrong length or level in the entries. This is visible at `rd_data` once the frame closes, one idle window after the last mark. A fault in the frame state shows as entries appearing before a qualifying mark, or as a missing packet-end flag. A fault in the FIFO pointers or flag logic appears in `status` in the cycle after the offending push, pop or clear, so the bench reads the count and flags right after each frame and after each clear.

// File: rtl/cir_rl_pkg.sv
package cir_rl_pkg;
   localparam int RUN_W = 7;
   localparam logic [RUN_W-1:0] RUN_MAX = '1;

   typedef struct packed {
      logic             mark;
      logic [RUN_W-1:0] len;
   } run_ent_t;

   typedef enum logic [1:0] {
      FR_WAIT = 2'd0,
      FR_RUN  = 2'd1
   } fr_state_t;

   localparam logic [1:0] MODE_IR = 2'b11;

   localparam int ST_OVF   = 0;
   localparam int ST_PEND  = 1;
   localparam int ST_AVAIL = 4;
   localparam int ST_CNT   = 8;
endpackage

// File: rtl/cir_rl_sampler.sv
module cir_rl_sampler #(
   parameter int DIV_FAST = 64,
   parameter int DIV_SLOW = 128,
   parameter int FILT_W   = 6,
   parameter int SYNC_N   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              slow_sel,
   input  logic              invert,
   input  logic [FILT_W-1:0] filt_thr,
   input  logic              ir_in,
   output logic              stb,
   output logic              level
);
   localparam int PW = $clog2(DIV_SLOW);

   generate
      if (DIV_FAST < 2 || DIV_SLOW < DIV_FAST) begin : g_bad_div
         $error("sampler: divider parameters out of range");
      end
      if (SYNC_N < 2) begin : g_bad_sync
         $error("sampler: at least two synchronizer stages required");
      end
   endgenerate

   logic [SYNC_N-1:0] sync_q;
   logic              smp;
   logic [PW-1:0]     pcnt;
   logic [PW-1:0]     plim;
   logic              tick;
   logic [FILT_W-1:0] dcnt;
   logic [FILT_W:0]   dnext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_N-2:0], ir_in ^ invert};
   end
   assign smp = sync_q[SYNC_N-1];

   assign plim = slow_sel ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         tick <= 1'b0;
      end else if (!run) begin
         pcnt <= '0;
         tick <= 1'b0;
      end else if (pcnt >= plim) begin
         pcnt <= '0;
         tick <= 1'b1;
      end else begin
         pcnt <= pcnt + 1'b1;
         tick <= 1'b0;
      end
   end

   assign dnext = {1'b0, dcnt} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= 1'b0;
         dcnt  <= '0;
         stb   <= 1'b0;
      end else if (!run) begin
         level <= 1'b0;
         dcnt  <= '0;
         stb   <= 1'b0;
      end else begin
         stb <= tick;
         if (tick) begin
            if (smp != level) begin
               if (dnext >= {1'b0, filt_thr}) begin
                  level <= smp;
                  dcnt  <= '0;
               end else begin
                  dcnt <= dnext[FILT_W-1:0];
               end
            end else begin
               dcnt <= '0;
            end
         end
      end
   end

   // R1: sample ticks are separated by at least one idle cycle
   p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R3: the filtered level only moves in the cycle its strobe follows
   p_level_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && level != $past(level)) |-> stb);
endmodule

// File: rtl/cir_rl_framer.sv
module cir_rl_framer
   import cir_rl_pkg::*;
#(
   parameter int THR_W     = 8,
   parameter int IDLE_UNIT = 128,
   parameter int ACT_SCALE = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             stb,
   input  logic             level,
   input  logic [THR_W-1:0] idle_thr,
   input  logic [THR_W-1:0] act_thr,
   input  logic             act_scale,
   output logic             push,
   output run_ent_t         push_ent,
   output logic             pkt_end
);
   localparam int AS_SH = $clog2(ACT_SCALE);
   localparam int ID_SH = $clog2(IDLE_UNIT);
   localparam int QW    = THR_W + AS_SH + 1;
   localparam int IW    = THR_W + ID_SH + 1;

   generate
      if ((1 << AS_SH) != ACT_SCALE) begin : g_bad_scale
         $error("framer: ACT_SCALE must be a power of two");
      end
      if ((1 << ID_SH) != IDLE_UNIT || IDLE_UNIT < 2) begin : g_bad_idle
         $error("framer: IDLE_UNIT must be a power of two of at least 2");
      end
   endgenerate

   fr_state_t        st;
   logic [QW-1:0]    qual;
   logic [QW-1:0]    qual_inc;
   logic [QW-1:0]    act_base;
   logic [QW-1:0]    act_need;
   logic [IW-1:0]    idle;
   logic [IW-1:0]    idle_inc;
   logic [IW-1:0]    idle_need;
   logic             cur;
   logic [RUN_W-1:0] rl;
   logic [RUN_W-1:0] rl_inc;

   assign qual_inc  = qual + 1'b1;
   assign act_base  = QW'(act_thr) + QW'(1);
   assign act_need  = act_scale ? (act_base << AS_SH) : act_base;
   assign idle_inc  = idle + 1'b1;
   assign idle_need = (IW'(idle_thr) + IW'(1)) << ID_SH;
   assign rl_inc    = rl + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= FR_WAIT;
         qual     <= '0;
         idle     <= '0;
         cur      <= 1'b0;
         rl       <= '0;
         push     <= 1'b0;
         push_ent <= '0;
         pkt_end  <= 1'b0;
      end else if (!run) begin
         st      <= FR_WAIT;
         qual    <= '0;
         idle    <= '0;
         cur     <= 1'b0;
         rl      <= '0;
         push    <= 1'b0;
         pkt_end <= 1'b0;
      end else begin
         push    <= 1'b0;
         pkt_end <= 1'b0;
         if (stb) begin
            case (st)
               FR_WAIT: begin
                  if (level) begin
                     if (qual_inc >= act_need) begin
                        st   <= FR_RUN;
                        cur  <= 1'b1;
                        rl   <= '0;
                        idle <= '0;
                        qual <= '0;
                     end else begin
                        qual <= qual_inc;
                     end
                  end else begin
                     qual <= '0;
                  end
               end
               FR_RUN: begin
                  if (level == cur) begin
                     if (rl_inc == RUN_MAX) begin
                        push     <= 1'b1;
                        push_ent <= '{mark: cur, len: RUN_MAX};
                        rl       <= '0;
                     end else begin
                        rl <= rl_inc;
                     end
                  end else begin
                     if (rl != '0) begin
                        push     <= 1'b1;
                        push_ent <= '{mark: cur, len: rl};
                     end
                     cur <= level;
                     rl  <= RUN_W'(1);
                  end
                  if (!level) begin
                     if (idle_inc >= idle_need) begin
                        push     <= 1'b1;
                        push_ent <= '{mark: 1'b0, len: (level == cur) ? rl_inc : RUN_W'(1)};
                        pkt_end  <= 1'b1;
                        st       <= FR_WAIT;
                        rl       <= '0;
                        idle     <= '0;
                        qual     <= '0;
                        cur      <= 1'b0;
                     end else begin
                        idle <= idle_inc;
                     end
                  end else begin
                     idle <= '0;
                  end
               end
               default: st <= FR_WAIT;
            endcase
         end
      end
   end

   // R2: every stored run has a length of at least one sample
   p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (push_ent.len != '0));

   // R5: the frame end always comes with a final space entry
   p_end_with_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_end |-> (push && !push_ent.mark));

   // R4: waiting for a qualifying mark never writes entries
   p_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_WAIT && !pkt_end) |=> !push || $past(st) != FR_WAIT);
endmodule

// File: rtl/cir_rl_fifo.sv
module cir_rl_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count,
   output logic          ovf_evt
);
   generate
      if ((1 << AW) != DEPTH || DEPTH < 4) begin : g_bad_depth
         $error("fifo: DEPTH must be a power of two of at least 4");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp;
   logic [AW-1:0] rp;
   logic          full;
   logic          empty;
   logic          do_push;
   logic          do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign ovf_evt = push & full;
   assign rdata   = empty ? '0 : mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R7: the fill count never exceeds the depth
   p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R7: a push into a full FIFO leaves it full
   p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (count == CW'(DEPTH)));

   // R12: a read of an empty FIFO leaves it empty
   p_empty_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/cir_rl_rx.sv
module cir_rl_rx
   import cir_rl_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int DIV_FAST  = 64,
   parameter int DIV_SLOW  = 128,
   parameter int FILT_W    = 6,
   parameter int THR_W     = 8,
   parameter int IDLE_UNIT = 128,
   parameter int ACT_SCALE = 128,
   localparam int LVL_W    = $clog2(DEPTH),
   localparam int CW       = LVL_W + 1,
   localparam int STAT_W   = ST_CNT + CW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glb_en,
   input  logic              rx_en,
   input  logic [1:0]        mode,
   input  logic              slow_sel,
   input  logic              invert,
   input  logic [FILT_W-1:0] filt_thr,
   input  logic [THR_W-1:0]  idle_thr,
   input  logic [THR_W-1:0]  act_thr,
   input  logic              act_scale,
   input  logic [LVL_W-1:0]  trig_lvl,
   input  logic [2:0]        irq_en,
   input  logic              clr_we,
   input  logic [7:0]        clr_mask,
   input  logic              ir_in,
   input  logic              rd_stb,
   output logic [7:0]        rd_data,
   output logic [STAT_W-1:0] status,
   output logic              irq
);
   logic     run;
   logic     stb;
   logic     level;
   logic     push;
   run_ent_t push_ent;
   logic     pkt_end;
   logic [CW-1:0] count;
   logic     ovf_evt;
   logic     ovf_q;
   logic     pend_q;
   logic     avail_q;
   logic     clr_ovf;
   logic     clr_pend;
   logic     clr_avail;

   assign run = glb_en & rx_en & (mode == MODE_IR);

   cir_rl_sampler #(
      .DIV_FAST (DIV_FAST),
      .DIV_SLOW (DIV_SLOW),
      .FILT_W   (FILT_W),
      .SYNC_N   (2)
   ) u_smp (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .slow_sel (slow_sel),
      .invert   (invert),
      .filt_thr (filt_thr),
      .ir_in    (ir_in),
      .stb      (stb),
      .level    (level)
   );

   cir_rl_framer #(
      .THR_W     (THR_W),
      .IDLE_UNIT (IDLE_UNIT),
      .ACT_SCALE (ACT_SCALE)
   ) u_frm (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .stb       (stb),
      .level     (level),
      .idle_thr  (idle_thr),
      .act_thr   (act_thr),
      .act_scale (act_scale),
      .push      (push),
      .push_ent  (push_ent),
      .pkt_end   (pkt_end)
   );

   cir_rl_fifo #(
      .DEPTH (DEPTH),
      .W     (8)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .wdata   (push_ent),
      .pop     (rd_stb),
      .rdata   (rd_data),
      .count   (count),
      .ovf_evt (ovf_evt)
   );

   assign clr_ovf   = clr_we & clr_mask[ST_OVF];
   assign clr_pend  = clr_we & clr_mask[ST_PEND];
   assign clr_avail = clr_we & clr_mask[ST_AVAIL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q   <= 1'b0;
         pend_q  <= 1'b0;
         avail_q <= 1'b0;
      end else begin
         ovf_q   <= (ovf_q & ~clr_ovf) | ovf_evt;
         pend_q  <= (pend_q & ~clr_pend) | pkt_end;
         avail_q <= (avail_q & ~clr_avail) | (count > CW'(trig_lvl));
      end
   end

   always_comb begin
      status                     = '0;
      status[ST_OVF]             = ovf_q;
      status[ST_PEND]            = pend_q;
      status[ST_AVAIL]           = avail_q;
      status[ST_CNT +: CW]       = count;
   end

   assign irq = |({avail_q, pend_q, ovf_q} & irq_en);

   // R7: overflow stays set until a clear names it
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr_ovf) |=> ovf_q);

   // R8: a fill above the level raises data-available
   p_avail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (count > CW'(trig_lvl)) |=> avail_q);

   // R5: frame end raises the packet-end flag
   p_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_end |=> pend_q);

   // R11: nothing is stored while reception is off
   p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !$past(run)) |-> !push);
endmodule

// File: tb/cir_rl_rx_test.sv
module cir_rl_rx_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       glb_en = 1'b0, rx_en = 1'b0, slow_sel = 1'b0, invert = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [5:0] filt_thr = 6'd1;
   logic [7:0] idle_thr = 8'd0, act_thr = 8'd3;
   logic       act_scale = 1'b0;
   logic [3:0] trig_lvl = 4'd7;
   logic [2:0] irq_en = 3'b000;
   logic       clr_we = 1'b0;
   logic [7:0] clr_mask = 8'h00;
   logic       ir_in = 1'b0, rd_stb = 1'b0;
   logic [7:0] rd_data;
   logic [12:0] status;
   logic       irq;

   int n_chk = 0, n_err = 0;
   int div_now = 64;
   bit inv_drive = 1'b0;

   always #4 clk = ~clk;

   cir_rl_rx uut (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .rx_en(rx_en), .mode(mode),
      .slow_sel(slow_sel), .invert(invert), .filt_thr(filt_thr),
      .idle_thr(idle_thr), .act_thr(act_thr), .act_scale(act_scale),
      .trig_lvl(trig_lvl), .irq_en(irq_en), .clr_we(clr_we),
      .clr_mask(clr_mask), .ir_in(ir_in), .rd_stb(rd_stb),
      .rd_data(rd_data), .status(status), .irq(irq)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_near(string req, int act, int exp);
      n_chk++;
      if (act < exp - 1 || act > exp + 1) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d (+-1)", req, act, exp);
      end
   endtask

   function automatic int fill();
      return int'(status[12:8]);
   endfunction

   task automatic hold(bit lvl, int n);
      ir_in = lvl ^ inv_drive;
      repeat (n * div_now) @(negedge clk);
   endtask

   task automatic pop(output int v);
      v = int'(rd_data);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic pop_chk(string req, int lvl, int len, bit exact);
      int v;
      pop(v);
      check({req, " level"}, (v >> 7) & 1, lvl);
      if (exact) check({req, " length"}, v & 127, len);
      else       check_near({req, " length"}, v & 127, len);
   endtask

   task automatic clear(logic [7:0] m);
      clr_mask = m;
      clr_we = 1'b1;
      @(negedge clk);
      clr_we = 1'b0;
      clr_mask = 8'h00;
   endtask

   task automatic drain();
      int v;
      while (fill() > 0) pop(v);
      clear(8'hff);
      @(negedge clk);
   endtask

   task automatic cfg(int filt, int t, bit sc);
      filt_thr = 6'(filt);
      act_thr = 8'(t);
      act_scale = sc;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R13 status after reset", int'(status), 0);
      check("R10 irq after reset", int'(irq), 0);
      check("R12 rd_data empty after reset", int'(rd_data), 0);
   endtask

   task automatic t_basic();
      cfg(1, 3, 1'b0);
      hold(0, 4);
      hold(1, 10); hold(0, 5); hold(1, 7); hold(0, 140);
      check("R13 fill field", fill(), 5);
      check("R5 packet-end bit1", int'(status[1]), 1);
      check("R13 overflow bit0", int'(status[0]), 0);
      check("R13 unused bits", int'(status[7:5]) + int'(status[3:2]), 0);
   endtask

   task automatic t_avail_irq();
      int v;
      irq_en = 3'b100;
      trig_lvl = 4'd3;
      @(negedge clk);
      check("R8 avail bit4 with fill 5 > 3", int'(status[4]), 1);
      check("R10 irq from avail", int'(irq), 1);
      pop_chk("R4 first mark excludes qualifying", 1, 6, 0);
      pop_chk("R2 space run", 0, 5, 0);
      clear(8'h10);
      check("R9 avail cleared at fill 3", int'(status[4]), 0);
      check("R9 pend kept", int'(status[1]), 1);
      check("R10 irq follows avail", int'(irq), 0);
      irq_en = 3'b010;
      @(negedge clk);
      check("R10 irq from pend", int'(irq), 1);
      irq_en = 3'b000;
      @(negedge clk);
      check("R10 irq masked", int'(irq), 0);
      pop_chk("R2 mark run", 1, 7, 0);
      pop_chk("R5 idle chunk", 0, 127, 1);
      pop_chk("R5 final space entry", 0, 1, 1);
      trig_lvl = 4'd7;
      drain();
   endtask

   task automatic t_glitch();
      cfg(4, 3, 1'b0);
      hold(0, 10);
      hold(1, 2); hold(0, 20);
      check("R3 short mark before frame ignored", fill(), 0);
      hold(1, 10); hold(0, 2); hold(1, 10); hold(0, 140);
      check("R3 glitch merged fill", fill(), 3);
      pop_chk("R3 merged mark", 1, 18, 0);
      pop_chk("R3 idle chunk", 0, 127, 1);
      drain();
   endtask

   task automatic t_active();
      cfg(1, 3, 1'b0);
      hold(1, 3); hold(0, 140);
      check("R4 mark of T samples stores nothing", fill(), 0);
      check("R4 no packet end", int'(status[1]), 0);
      cfg(1, 0, 1'b1);
      hold(1, 100); hold(0, 20);
      check("R4 scaled threshold not met", fill(), 0);
      hold(1, 130); hold(0, 140);
      check("R4 scaled frame fill", fill(), 3);
      pop_chk("R4 scaled first entry", 1, 2, 0);
      drain();
   endtask

   task automatic t_chunk();
      cfg(1, 3, 1'b0);
      hold(1, 134); hold(0, 140);
      check("R2 long run fill", fill(), 4);
      pop_chk("R2 saturated entry", 1, 127, 1);
      pop_chk("R2 continuation", 1, 3, 0);
      pop_chk("R2 space chunk", 0, 127, 1);
      drain();
   endtask

   task automatic t_invert();
      cfg(1, 3, 1'b0);
      invert = 1'b1; inv_drive = 1'b1; ir_in = 1'b1;
      hold(0, 10);
      hold(1, 10); hold(0, 5); hold(1, 7); hold(0, 140);
      check("R6 inverted frame fill", fill(), 5);
      pop_chk("R6 inverted mark", 1, 6, 0);
      pop_chk("R6 inverted space", 0, 5, 0);
      invert = 1'b0; inv_drive = 1'b0; ir_in = 1'b0;
      drain();
   endtask

   task automatic t_disable();
      mode = 2'b10;
      hold(0, 4); hold(1, 20); hold(0, 10);
      check("R11 wrong mode stores nothing", fill(), 0);
      mode = 2'b11; glb_en = 1'b0;
      hold(1, 20); hold(0, 10);
      check("R11 global off stores nothing", fill(), 0);
      glb_en = 1'b1; rx_en = 1'b0;
      hold(1, 20); hold(0, 10);
      check("R11 receive off stores nothing", fill(), 0);
      rx_en = 1'b1;
      hold(0, 10);
   endtask

   task automatic t_overflow();
      int v;
      cfg(1, 0, 1'b0);
      for (int k = 0; k < 10; k++) begin
         hold(1, 2); hold(0, 2);
      end
      hold(0, 140);
      check("R7 fill stays at depth", fill(), 16);
      check("R7 overflow bit0", int'(status[0]), 1);
      pop_chk("R7 oldest kept", 1, 1, 0);
      clear(8'h01);
      check("R9 overflow cleared", int'(status[0]), 0);
      check("R9 pend untouched", int'(status[1]), 1);
      for (int k = 0; k < 15; k++) pop(v);
      check("R12 empty after reads", fill(), 0);
      check("R12 empty rd_data", int'(rd_data), 0);
      pop(v);
      check("R12 read on empty ignored", fill(), 0);
      clear(8'hff);
   endtask

   task automatic t_slow();
      cfg(1, 3, 1'b0);
      slow_sel = 1'b1; div_now = 128;
      hold(0, 4);
      hold(1, 10); hold(0, 140);
      check("R1 slow frame fill", fill(), 3);
      pop_chk("R1 mark at /128", 1, 6, 0);
      pop_chk("R1 idle chunk at /128", 0, 127, 1);
      slow_sel = 1'b0; div_now = 64;
      drain();
   endtask

   task automatic run_all();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      glb_en = 1'b1; rx_en = 1'b1; mode = 2'b11;
      t_basic();
      t_avail_irq();
      t_glitch();
      t_active();
      t_chunk();
      t_invert();
      t_disable();
      t_overflow();
      t_slow();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (195000) @(posedge clk);
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule